// File: doc/BRIEF.md
# Circular Buffer Write Address Generator

This block produces the write address for a ring of raw-sample memories that is 2048 locations deep. It also produces a shared write enable for those memories. Software sets it up through a small register port. It writes the enable bits and the highest-address word. It then writes a control word with the start bit set. The generator arms and waits for the next begin-of-turn marker. From that marker it counts one location per clock, starting at address 0.

In multi-turn mode the count wraps from 2047 back to 0 and keeps going. In single-pass mode it halts at 2047. A save-monitor event freezes the counter when the save-stop enable is set, and the address at that moment is copied into a stop register for software to read. The ring length is fixed, and turns are not a whole number of rings. Separate instances therefore halt at different addresses.

There is no flow-controlled data path here. The register port and the strobes are plain single-cycle signals with no back-pressure.

Top module: `ringaddr_gen`

## Requirements
- R1: After reset the address output is 0, the global write enable is low, the control register reads 0, the highest-address register reads 2047 and the stop register reads 0.
- R2: Register 513 holds an 11-bit highest address that reads back as written. Register 514 is read-only: a write to it leaves its value unchanged. Read data appears on the clock after the read strobe.
- R3: The control register at 512 uses three enable bits: bit 1 selects multi-turn, bit 2 enables the global write enable and bit 3 lets a save event stop the counter. Bit 0 is a start strobe and reads back as 0.
- R4: A control write with bit 0 set arms the generator and holds the address at 0 with the write enable low. The first clock after a begin-of-turn marker shows address 0 in the running state.
- R5: While running, the address rises by one each clock. A begin-of-turn marker that arrives during running has no effect.
- R6: With multi-turn set, address 2047 is followed by address 0 and counting continues.
- R7: With multi-turn clear, the counter halts at 2047 and the stop register reads 2047.
- R8: The global write enable is high in every running cycle when bit 2 is set. It is low in every cycle once the generator has halted, and low throughout when bit 2 is clear.
- R9: A save pulse while running with bit 3 set freezes the address at its value in the pulse cycle. From the next clock the write enable is low, and the stop register reads that address.
- R10: A save pulse with bit 3 clear is ignored, and counting continues without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the clock after reg_rd |
| turn_mark | input | 1 | Begin-of-turn marker |
| save_evt | input | 1 | Save-monitor event strobe |
| wr_addr | output | 11 | Ring write address |
| gwe | output | 1 | Global write enable to the memories |

## Verification
A wrong state would show at the ports as the address taking a wrong step on the very next clock. It could also show as a write enable that stays high after a freeze, or that rises while armed. A stop value that was captured wrongly shows only on the next read of register 514. The bench therefore reads that register straight after every halt.

// File: rtl/ringaddr_pkg.sv
package ringaddr_pkg;
  typedef enum logic [1:0] {
    GEN_IDLE  = 2'd0,
    GEN_ARMED = 2'd1,
    GEN_RUN   = 2'd2,
    GEN_HALT  = 2'd3
  } gen_state_e;

  localparam int CTRL_OFS = 512;
  localparam int HIGH_OFS = 513;
  localparam int STOP_OFS = 514;

  localparam int BIT_START = 0;
  localparam int BIT_MULTI = 1;
  localparam int BIT_GWE   = 2;
  localparam int BIT_SAVE  = 3;
endpackage

// File: rtl/ringaddr_regs.sv
module ringaddr_regs
  import ringaddr_pkg::*;
#(
  parameter int AW  = 11,
  parameter int RAW = 10,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [AW-1:0]  stop_addr,
  output logic           arm_pulse,
  output logic           en_multi,
  output logic           en_gwe,
  output logic           en_save
);
  localparam logic [RAW-1:0] A_CTRL = RAW'(CTRL_OFS);
  localparam logic [RAW-1:0] A_HIGH = RAW'(HIGH_OFS);
  localparam logic [RAW-1:0] A_STOP = RAW'(STOP_OFS);
  localparam int PADW = DW - AW;

  logic [AW-1:0] high_q;
  logic          wr_ctrl;
  logic [DW-1:0] rd_mux;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign arm_pulse = wr_ctrl && reg_wdata[BIT_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_multi <= 1'b0;
      en_gwe   <= 1'b0;
      en_save  <= 1'b0;
      high_q   <= '1;
    end else begin
      if (wr_ctrl) begin
        en_multi <= reg_wdata[BIT_MULTI];
        en_gwe   <= reg_wdata[BIT_GWE];
        en_save  <= reg_wdata[BIT_SAVE];
      end
      if (reg_wr && reg_addr == A_HIGH) high_q <= reg_wdata[AW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[BIT_MULTI] = en_multi;
        rd_mux[BIT_GWE]   = en_gwe;
        rd_mux[BIT_SAVE]  = en_save;
      end
      A_HIGH:  rd_mux = {{PADW{1'b0}}, high_q};
      A_STOP:  rd_mux = {{PADW{1'b0}}, stop_addr};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable({en_multi, en_gwe, en_save}));
endmodule

// File: rtl/ringaddr_seq.sv
module ringaddr_seq
  import ringaddr_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_pulse,
  input  logic          en_multi,
  input  logic          en_gwe,
  input  logic          en_save,
  input  logic          turn_mark,
  input  logic          save_evt,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] stop_addr,
  output logic          gwe
);
  localparam logic [AW-1:0] LAST = '1;

  gen_state_e state;
  logic       save_hit;
  logic       at_end;

  assign save_hit = save_evt && en_save;
  assign at_end   = (addr == LAST);
  assign gwe      = (state == GEN_RUN) && en_gwe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= GEN_IDLE;
      addr      <= '0;
      stop_addr <= '0;
    end else if (arm_pulse) begin
      state <= GEN_ARMED;
      addr  <= '0;
    end else begin
      case (state)
        GEN_ARMED: if (turn_mark) begin
          state <= GEN_RUN;
          addr  <= '0;
        end
        GEN_RUN: begin
          if (save_hit || (at_end && !en_multi)) begin
            state     <= GEN_HALT;
            stop_addr <= addr;
          end else begin
            addr <= addr + AW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assert_start_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GEN_ARMED && turn_mark && !arm_pulse) |=> (state == GEN_RUN && addr == '0));
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GEN_RUN && !arm_pulse && !save_hit && !at_end) |=> (addr == $past(addr) + AW'(1)));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GEN_RUN && !arm_pulse && !save_hit && at_end && en_multi) |=> (state == GEN_RUN && addr == '0));
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GEN_RUN && !arm_pulse && save_hit) |=> (!gwe && stop_addr == $past(addr) && addr == $past(addr)));
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GEN_HALT && !arm_pulse) |=> ($stable(addr) && !gwe));
  assert_save_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GEN_RUN && !arm_pulse && save_evt && !en_save && !at_end) |=> state == GEN_RUN);
endmodule

// File: rtl/ringaddr_gen.sv
module ringaddr_gen
  import ringaddr_pkg::*;
#(
  parameter int AW  = 11,
  parameter int RAW = 10,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           turn_mark,
  input  logic           save_evt,
  output logic [AW-1:0]  wr_addr,
  output logic           gwe
);
  logic          arm_pulse, en_multi, en_gwe, en_save;
  logic [AW-1:0] stop_addr;

  ringaddr_regs #(.AW(AW), .RAW(RAW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stop_addr(stop_addr), .arm_pulse(arm_pulse), .en_multi(en_multi),
    .en_gwe(en_gwe), .en_save(en_save)
  );

  ringaddr_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm_pulse(arm_pulse), .en_multi(en_multi),
    .en_gwe(en_gwe), .en_save(en_save), .turn_mark(turn_mark),
    .save_evt(save_evt), .addr(wr_addr), .stop_addr(stop_addr), .gwe(gwe)
  );

  assert_arm_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse |=> (wr_addr == '0 && !gwe));
endmodule

// File: tb/ringaddr_gen_tb.sv
module ringaddr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        turn_mark = 1'b0, save_evt = 1'b0;
  logic [10:0] wr_addr;
  logic        gwe;

  int checks = 0;
  int fails  = 0;

  typedef struct { int a; bit g; string tag; } exp_t;
  exp_t q[$];

  ringaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .turn_mark(turn_mark), .save_evt(save_evt), .wr_addr(wr_addr), .gwe(gwe)
  );

  always #10 clk = ~clk;

  // monitor: compares one queued item per clock
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(wr_addr) != e.a || gwe != e.g) begin
        fails++;
        $display("FAIL %s: addr/gwe actual %0d/%0b expected %0d/%0b",
                 e.tag, wr_addr, gwe, e.a, e.g);
      end
    end
  end

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 10'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic start(int enables);
    wr(512, enables);
    wr(512, enables | 1);
    wr(512, enables);
  endtask

  // marker, then n expected cycles; returns on the negedge where addr n-1 shows
  task automatic run_pass(int n, bit multi, bit g, int extra_turn, string tag);
    @(negedge clk);
    turn_mark = 1'b1;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.a = multi ? (i % 2048) : ((i > 2047) ? 2047 : i);
      e.g = g && (multi || i < 2048);
      e.tag = tag;
      q.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      turn_mark = (i + 1 == extra_turn);
    end
    turn_mark = 1'b0;
  endtask

  task automatic save_pulse(int cur, bit frozen, bit g, string tag);
    save_evt = 1'b1;
    for (int j = 0; j < 4; j++) begin
      exp_t e;
      e.a = frozen ? cur : cur + 1 + j;
      e.g = frozen ? 1'b0 : g;
      e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    save_evt = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 addr", int'(wr_addr), 0);
    check("R1 gwe", int'(gwe), 0);
    rd(512, d); check("R1 ctrl", d, 0);
    rd(513, d); check("R1 high", d, 2047);
    rd(514, d); check("R1 stop", d, 0);
    // R2 register behaviour
    wr(513, 2046); rd(513, d); check("R2 high readback", d, 2046);
    wr(514, 16'h0123); rd(514, d); check("R2 stop read-only", d, 0);
    // R3 control word, R4 armed waits
    start(16'h000E);
    rd(512, d); check("R3 ctrl readback", d, 16'h000E);
    repeat (8) @(negedge clk);
    check("R4 armed addr", int'(wr_addr), 0);
    check("R4 armed gwe", int'(gwe), 0);
    // R4 R5 R8 run with a stray marker, then R9 freeze
    run_pass(300, 1'b1, 1'b1, 100, "R5 count");
    save_pulse(299, 1'b1, 1'b1, "R9 freeze");
    rd(514, d); check("R9 stop addr", d, 299);
    // R10 save disabled
    start(16'h0006);
    run_pass(50, 1'b1, 1'b1, 0, "R5 count2");
    save_pulse(49, 1'b0, 1'b1, "R10 ignored");
    rd(514, d); check("R10 stop unchanged", d, 299);
    // R7 single pass
    start(16'h000C);
    run_pass(2052, 1'b0, 1'b1, 0, "R7 single pass");
    rd(514, d); check("R7 stop at end", d, 2047);
    // R6 wrap with write enable off (R8)
    start(16'h000A);
    run_pass(2068, 1'b1, 1'b0, 0, "R6 wrap");
    save_pulse(19, 1'b1, 1'b0, "R9 freeze after wrap");
    rd(514, d); check("R9 stop after wrap", d, 19);
    check("R8 gwe low halted", int'(gwe), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule